// File: doc/BRIEF.md
# Raster Dot and Line Timing Generator

This block produces the raster timeline for a tile-based video processor. A divider slows the master clock to a dot rate. A horizontal dot counter and a vertical line counter run at that rate. The lines per frame come from a region select, and the height of the visible area comes from an overscan select. From the two counters the block decodes a visible-pixel window, a vertical blanking flag, pulses at the start of each line and each frame, and a render strobe at one fixed dot on every visible line. Downstream logic uses these signals to schedule line compositing and blank-period work.

A small state machine follows the vertical position through the frame. It has three states:
- `PH_TOP`: line 0.
- `PH_ACTIVE`: the visible lines.
- `PH_VBLANK`: from the first blank line to the frame end.

It has four transitions, all taken on the dot enable of the last dot of a line:
- `PH_TOP -> PH_ACTIVE`: at the end of line 0.
- `PH_ACTIVE -> PH_VBLANK`: at the end of the last visible line.
- `PH_VBLANK -> PH_TOP`: at the end of the last line of the frame.
- `PH_ACTIVE -> PH_TOP`: if a frame end ever coincides with the active phase.

The region and overscan inputs are sampled only at the frame wrap, so a frame never mixes two settings.

Top module: `raster_timer`

## Requirements
- R1: `dot_en` is high for exactly one master clock in every four (`DOT_DIV`). The first pulse after reset comes on the fourth clock.
- R2: `h_cnt` advances by one on each dot enable, runs 0 to 339, and goes from 339 back to 0 while `v_cnt` advances by one.
- R3: `v_cnt` wraps to 0 after line 261 when the latched region is NTSC (`region_pal`=0) and after line 311 when it is PAL (`region_pal`=1).
- R4: `active` is high exactly for dots 22 to 277 inclusive on visible lines, and low at dots 21 and 278.
- R5: The visible lines are 1 to 224 with the latched overscan setting 0, and 1 to 239 with it set to 1. Line 0 is never visible.
- R6: `vblank` is high from line 225 (overscan 0) or line 240 (overscan 1) until the frame wraps. It is low on line 0, and it is never high together with `active`.
- R7: `pal_status` reports the latched region: 1 for PAL, 0 for NTSC.
- R8: `render_strobe` is high for one dot-enable cycle at dot `RENDER_DOT` (default 278) on each visible line, and never on line 0 or blank lines.
- R9: A change on `region_pal` or `overscan_en` has no effect on the frame in progress. It takes effect from the next frame's line 0.
- R10: With `rst` high at a clock edge, H, V and the prescaler go to 0, `vblank` goes low, and the region and overscan inputs are latched.
- R11: `line_start` is high on the dot enable where `h_cnt` is 0. `frame_start` is high on the dot enable where both `h_cnt` and `v_cnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| region_pal | input | 1 | Region select: 1 = PAL, 0 = NTSC |
| overscan_en | input | 1 | Tall visible area select |
| dot_en | output | 1 | One-clock pulse per dot |
| h_cnt | output | 9 | Horizontal dot position |
| v_cnt | output | 9 | Vertical line position |
| active | output | 1 | Visible pixel window |
| vblank | output | 1 | Vertical blanking flag |
| line_start | output | 1 | First dot of a line |
| frame_start | output | 1 | First dot of a frame |
| render_strobe | output | 1 | Per-line render point on visible lines |
| pal_status | output | 1 | Latched region status bit |

## Verification
The bench probes the edges of the visible window at dots 21, 22, 277 and 278. A one-off comparison there would widen or shift the window by a pixel. It switches region and overscan in the middle of a frame. A design that applies such a change at once would wrap the frame at the wrong line or move the blank boundary inside the current frame. The bench also follows both frame lengths through the wrap and checks the blank flag on the last visible line and the first blank line. A wrong terminal line or a wrong transition out of the state machine shows up there as an early or late wrap, or a missing `frame_start`. To stay within its run length, the bench shortens the vertical geometry through parameters and keeps the horizontal timing at its full default.

// File: rtl/raster_pkg.sv
package raster_pkg;
    typedef enum logic [1:0] {
        PH_TOP    = 2'd0,
        PH_ACTIVE = 2'd1,
        PH_VBLANK = 2'd2
    } phase_t;
endpackage

// File: rtl/dot_prescaler.sv
module dot_prescaler #(
    parameter int DOT_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic dot_en
);
    localparam int CW = (DOT_DIV > 1) ? $clog2(DOT_DIV) : 1;
    localparam logic [CW-1:0] TERM = CW'(DOT_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == TERM) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign dot_en = (cnt == TERM);

    // R1: a dot enable is never followed directly by another one
    assert_dot_spacing_R1: assert property (@(posedge clk) disable iff (rst)
        dot_en |=> !dot_en);
endmodule

// File: rtl/hv_counter.sv
module hv_counter #(
    parameter int H_TOTAL    = 340,
    parameter int LINES_NTSC = 262,
    parameter int LINES_PAL  = 312,
    parameter int HW         = 9,
    parameter int VW         = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dot_en,
    input  logic          region_pal,
    input  logic          overscan_en,
    output logic [HW-1:0] h,
    output logic [VW-1:0] v,
    output logic          pal_q,
    output logic          ovs_q,
    output logic          line_end,
    output logic          frame_end
);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] VL_NTSC = VW'(LINES_NTSC - 1);
    localparam logic [VW-1:0] VL_PAL  = VW'(LINES_PAL - 1);

    logic [VW-1:0] v_last;

    assign v_last    = pal_q ? VL_PAL : VL_NTSC;
    assign line_end  = dot_en && (h == H_LAST);
    assign frame_end = line_end && (v == v_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            h     <= '0;
            v     <= '0;
            pal_q <= region_pal;
            ovs_q <= overscan_en;
        end else if (dot_en) begin
            if (line_end) begin
                h <= '0;
                if (frame_end) begin
                    v     <= '0;
                    pal_q <= region_pal;
                    ovs_q <= overscan_en;
                end else begin
                    v <= v + 1'b1;
                end
            end else begin
                h <= h + 1'b1;
            end
        end
    end

    // R2: after the last dot the next dot is 0
    assert_h_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        line_end |=> (h == '0));
    assert_h_range_R2: assert property (@(posedge clk) disable iff (rst)
        h <= H_LAST);
    // R3: the frame wraps to line 0 and never exceeds the region's last line
    assert_v_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (v == '0));
    assert_v_range_R3: assert property (@(posedge clk) disable iff (rst)
        v <= v_last);
    // R9: latched configuration changes only at a frame wrap
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> ($stable(pal_q) && $stable(ovs_q)));
endmodule

// File: rtl/raster_phase_fsm.sv
module raster_phase_fsm
    import raster_pkg::*;
#(
    parameter int VW       = 9,
    parameter int ACT_STD  = 224,
    parameter int ACT_OVS  = 239
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_end,
    input  logic          frame_end,
    input  logic [VW-1:0] v,
    input  logic          ovs_q,
    output logic          active_line,
    output logic          vblank
);
    localparam logic [VW-1:0] LAST_STD = VW'(ACT_STD);
    localparam logic [VW-1:0] LAST_OVS = VW'(ACT_OVS);

    phase_t        state, state_nx;
    logic [VW-1:0] act_last;

    assign act_last = ovs_q ? LAST_OVS : LAST_STD;

    always_ff @(posedge clk) begin
        if (rst) state <= PH_TOP;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (line_end) begin
            unique case (state)
                PH_TOP:    state_nx = PH_ACTIVE;
                PH_ACTIVE: begin
                    if (frame_end)            state_nx = PH_TOP;
                    else if (v == act_last)   state_nx = PH_VBLANK;
                end
                PH_VBLANK: begin
                    if (frame_end)            state_nx = PH_TOP;
                end
                default:                      state_nx = PH_TOP;
            endcase
        end
    end

    always_comb begin
        active_line = 1'b0;
        vblank      = 1'b0;
        unique case (state)
            PH_TOP:    ;
            PH_ACTIVE: active_line = 1'b1;
            PH_VBLANK: vblank      = 1'b1;
            default:   ;
        endcase
    end

    // R5: the visible phase only ever spans lines 1..last visible line
    assert_phase_lines_R5: assert property (@(posedge clk) disable iff (rst)
        (state == PH_ACTIVE) |-> ((v != '0) && (v <= act_last)));
    // R6: line 0 is never part of blanking
    assert_top_not_blank_R6: assert property (@(posedge clk) disable iff (rst)
        (v == '0) |-> !vblank);
endmodule

// File: rtl/raster_timer.sv
module raster_timer #(
    parameter int DOT_DIV    = 4,
    parameter int H_TOTAL    = 340,
    parameter int ACT_FIRST  = 22,
    parameter int ACT_WIDTH  = 256,
    parameter int LINES_NTSC = 262,
    parameter int LINES_PAL  = 312,
    parameter int ACT_STD    = 224,
    parameter int ACT_OVS    = 239,
    parameter int RENDER_DOT = 278,
    localparam int HW = $clog2(H_TOTAL),
    localparam int VW = $clog2((LINES_PAL > LINES_NTSC) ? LINES_PAL : LINES_NTSC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          region_pal,
    input  logic          overscan_en,
    output logic          dot_en,
    output logic [HW-1:0] h_cnt,
    output logic [VW-1:0] v_cnt,
    output logic          active,
    output logic          vblank,
    output logic          line_start,
    output logic          frame_start,
    output logic          render_strobe,
    output logic          pal_status
);
    localparam logic [HW-1:0] WIN_LO = HW'(ACT_FIRST);
    localparam logic [HW-1:0] WIN_HI = HW'(ACT_FIRST + ACT_WIDTH - 1);
    localparam logic [HW-1:0] RDOT   = HW'(RENDER_DOT);

    logic ovs_q, line_end, frame_end, active_line;

    dot_prescaler #(.DOT_DIV(DOT_DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .dot_en (dot_en)
    );

    hv_counter #(
        .H_TOTAL(H_TOTAL), .LINES_NTSC(LINES_NTSC), .LINES_PAL(LINES_PAL),
        .HW(HW), .VW(VW)
    ) u_hv (
        .clk         (clk),
        .rst         (rst),
        .dot_en      (dot_en),
        .region_pal  (region_pal),
        .overscan_en (overscan_en),
        .h           (h_cnt),
        .v           (v_cnt),
        .pal_q       (pal_status),
        .ovs_q       (ovs_q),
        .line_end    (line_end),
        .frame_end   (frame_end)
    );

    raster_phase_fsm #(.VW(VW), .ACT_STD(ACT_STD), .ACT_OVS(ACT_OVS)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .line_end    (line_end),
        .frame_end   (frame_end),
        .v           (v_cnt),
        .ovs_q       (ovs_q),
        .active_line (active_line),
        .vblank      (vblank)
    );

    assign active        = active_line && (h_cnt >= WIN_LO) && (h_cnt <= WIN_HI);
    assign line_start    = dot_en && (h_cnt == '0);
    assign frame_start   = line_start && (v_cnt == '0);
    assign render_strobe = dot_en && active_line && (h_cnt == RDOT);

    // R6: blanking and visible pixels never overlap
    assert_blank_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(vblank && active));
    // R8: the render strobe lasts a single clock and never falls in blanking
    assert_render_single_R8: assert property (@(posedge clk) disable iff (rst)
        render_strobe |=> !render_strobe);
    assert_render_not_blank_R8: assert property (@(posedge clk) disable iff (rst)
        render_strobe |-> !vblank);
endmodule

// File: tb/raster_timer_tb.sv
module raster_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int L_NTSC = 26;
    localparam int L_PAL  = 31;
    localparam int A_STD  = 20;
    localparam int A_OVS  = 23;
    localparam int RDOT   = 278;
    localparam int HW = $clog2(340);
    localparam int VW = $clog2(L_PAL);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic region_pal = 1'b0;
    logic overscan_en = 1'b0;
    logic dot_en, active, vblank, line_start, frame_start, render_strobe, pal_status;
    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    raster_timer #(
        .LINES_NTSC(L_NTSC), .LINES_PAL(L_PAL),
        .ACT_STD(A_STD), .ACT_OVS(A_OVS), .RENDER_DOT(RDOT)
    ) u_dut (
        .clk(clk), .rst(rst), .region_pal(region_pal), .overscan_en(overscan_en),
        .dot_en(dot_en), .h_cnt(h_cnt), .v_cnt(v_cnt), .active(active),
        .vblank(vblank), .line_start(line_start), .frame_start(frame_start),
        .render_strobe(render_strobe), .pal_status(pal_status)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (h=%0d v=%0d)", req, act, exp, h_cnt, v_cnt);
        end
    endtask

    // wait for the dot-enable cycle at position (hh, vv), sampled at negedge
    task automatic goto(input int hh, input int vv);
        @(negedge clk);
        while (!(dot_en && h_cnt == hh && v_cnt == vv)) @(negedge clk);
    endtask

    task automatic next_dot();
        @(negedge clk);
        while (!dot_en) @(negedge clk);
    endtask

    task automatic t_reset_R10();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(h_cnt == 0, "R10 h", h_cnt, 0);
        chk(v_cnt == 0, "R10 v", v_cnt, 0);
        chk(vblank == 0, "R10 vblank", vblank, 0);
        chk(dot_en == 0, "R10 dot_en", dot_en, 0);
        chk(pal_status == 0, "R7 status ntsc", pal_status, 0);
    endtask

    task automatic t_prescaler_R1();
        int n = 0;
        bit prev = 1'b0;
        for (int i = 1; i <= 16; i++) begin
            @(negedge clk);
            if (dot_en) n++;
            if (i == 3) begin
                chk(dot_en == 1, "R1 first pulse", dot_en, 1);
                chk(frame_start == 1, "R11 frame_start", frame_start, 1);
                chk(line_start == 1, "R11 line_start", line_start, 1);
            end
            if (prev && dot_en) chk(0, "R1 back-to-back", 1, 0);
            prev = dot_en;
        end
        chk(n == 4, "R1 pulses per 16", n, 4);
        chk(h_cnt == 4, "R2 h after 4 dots", h_cnt, 4);
    endtask

    task automatic t_line_wrap_R2();
        goto(339, 0);
        chk(line_start == 0, "R11 no line_start mid", line_start, 0);
        next_dot();
        chk(h_cnt == 0, "R2 h wrap", h_cnt, 0);
        chk(v_cnt == 1, "R2 v step", v_cnt, 1);
        chk(line_start == 1, "R11 line_start", line_start, 1);
        chk(frame_start == 0, "R11 no frame_start", frame_start, 0);
    endtask

    task automatic t_window_R4();
        goto(21, 1);  chk(active == 0, "R4 dot 21", active, 0);
        goto(22, 1);  chk(active == 1, "R4 dot 22", active, 1);
        goto(277, 1); chk(active == 1, "R4 dot 277", active, 1);
        chk(render_strobe == 0, "R8 no strobe 277", render_strobe, 0);
        goto(278, 1); chk(active == 0, "R4 dot 278", active, 0);
        chk(render_strobe == 1, "R8 strobe at dot", render_strobe, 1);
        @(negedge clk);
        chk(render_strobe == 0, "R8 one clock", render_strobe, 0);
        goto(279, 1); chk(render_strobe == 0, "R8 no strobe 279", render_strobe, 0);
    endtask

    task automatic t_ntsc_frame_R5();
        goto(100, A_STD);     chk(active == 1, "R5 last visible line", active, 1);
        chk(vblank == 0, "R6 no blank visible", vblank, 0);
        goto(RDOT, A_STD + 1); chk(render_strobe == 0, "R8 none in blank", render_strobe, 0);
        goto(100, A_STD + 1); chk(active == 0, "R5 first blank line", active, 0);
        chk(vblank == 1, "R6 blank starts", vblank, 1);
        // R9: region changed mid-frame must not affect this frame
        region_pal = 1'b1;
        goto(339, L_NTSC - 1);
        chk(vblank == 1, "R6 blank till wrap", vblank, 1);
        chk(pal_status == 0, "R9 status held", pal_status, 0);
        next_dot();
        chk(v_cnt == 0, "R3 ntsc wrap", v_cnt, 0);
        chk(frame_start == 1, "R11 frame_start wrap", frame_start, 1);
        chk(vblank == 0, "R6 blank ends", vblank, 0);
        chk(pal_status == 1, "R7 status pal", pal_status, 1);
        goto(100, 0); chk(active == 0, "R5 line 0 hidden", active, 0);
        goto(RDOT, 0); chk(render_strobe == 0, "R8 none on line 0", render_strobe, 0);
    endtask

    task automatic t_pal_frame_R3();
        goto(339, L_NTSC - 1);
        // R9: overscan changed mid-frame
        overscan_en = 1'b1;
        next_dot();
        chk(v_cnt == L_NTSC, "R3 pal no early wrap", v_cnt, L_NTSC);
        goto(339, L_PAL - 1);
        next_dot();
        chk(v_cnt == 0, "R3 pal wrap", v_cnt, 0);
        chk(frame_start == 1, "R11 pal frame_start", frame_start, 1);
    endtask

    task automatic t_overscan_R9();
        // previous PAL frame had overscan off: checked at its line A_STD+1 below
        goto(100, A_OVS);     chk(active == 1, "R5 overscan last line", active, 1);
        goto(RDOT, A_OVS);    chk(render_strobe == 1, "R8 strobe overscan", render_strobe, 1);
        goto(100, A_OVS + 1); chk(active == 0, "R5 overscan blank", active, 0);
        chk(vblank == 1, "R6 overscan blank start", vblank, 1);
    endtask

    task automatic t_ovs_hold_R9();
        goto(100, A_STD + 1);
        chk(vblank == 1, "R9 old overscan kept", vblank, 1);
        chk(active == 0, "R9 old window kept", active, 0);
    endtask

    initial begin
        t_reset_R10();
        t_prescaler_R1();
        t_line_wrap_R2();
        t_window_R4();
        t_ntsc_frame_R5();
        // PAL frame, overscan changed inside it, then held until the wrap
        goto(0, 5);
        overscan_en = 1'b1;
        t_ovs_hold_R9();
        t_pal_frame_R3();
        t_overscan_R9();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule